// File: doc/BRIEF.md
# Serial Port Status Flags with Armed Clearing

This block keeps the nine condition flags of a serial communications port: two transmit flags (transmit buffer empty, transmission complete) and seven receive flags (receive buffer full, receiver active, line idle, overrun, noise, framing error, parity error). The transmitter and receiver raise flags with one-cycle set pulses. Software never clears a flag by writing to it. A flag clears only through a two-step sequence. First, a status-register read finds the flag at 1, which arms it. Second, an access to the data register completes the clear. Receive flags need a data read to complete. Transmit flags need a data write.

Each flag is handled by its own small state machine with three states:

- `FS_CLEAR`: the flag is 0.
- `FS_PENDING`: the flag is 1 and not armed.
- `FS_ARMED`: the flag is 1 and armed.

The transitions are:

- `SET`: a set pulse moves any state to `FS_PENDING`.
- `ARM`: a status read moves `FS_PENDING` to `FS_ARMED`.
- `FINISH`: the matching data access moves `FS_ARMED` to `FS_CLEAR`.
- `SWEEP`: a 32-bit combined read moves a receive flag in `FS_PENDING` or `FS_ARMED` straight to `FS_CLEAR`.

A set pulse takes priority over every other event. A flag that is raised again between the arming read and the data access therefore loses its arming.

The bus side is a single-cycle access port. It carries an enable, a write bit, a register select, a size code and write data. Read data is combinational in the same cycle. The block also passes out one-cycle strobes that the external data buffers use to consume or load a character.

Top module: `uart_flag_unit`

## Requirements
- R1: After reset, `flags_o` equals 9'h180. Transmit-empty (bit 8) and transmit-complete (bit 7) are 1 and all receive flags (bits 6..0) are 0.
- R2: Status reads present the 16-bit status word `{7'b0, flags}` with bits 15..9 reading 0. Size code 0 (low byte) returns bits 7..0 in `rd_data_o[7:0]`. Size code 1 (high byte) returns bits 15..8 in `rd_data_o[7:0]`. Size code 2 (half-word) returns the word in `rd_data_o[15:0]`. All unused `rd_data_o` bits are 0.
- R3: A receive flag (bits 6..0) that was 1 during a status read clears after a later data-register read of size low byte or half-word. A data-register write does not clear a receive flag.
- R4: A transmit flag (bits 8..7) that was 1 during a status read clears after a later data-register write of size low byte or half-word. A data-register read does not clear a transmit flag.
- R5: A data-register access clears no flag that has not been armed by an earlier status read.
- R6: A flag set after the arming status read but before the data access is not cleared by that access. Flags that were already armed are cleared. The newly set flag clears only after a fresh status read and a fresh data access.
- R7: A read with size code 3 is the combined read, whatever the register select. It returns `{status word, rx_data_i}` on `rd_data_o`. On the next cycle every receive flag that was 1 is cleared. Transmit flags stay 1 but become armed.
- R8: Writes to the status register (select 0) never change any flag and never disarm one.
- R9: A byte read of either half of the status register arms every flag that is set, including flags in the other byte.
- R10: When a set pulse and a clearing access hit a flag in the same cycle, the flag stays 1 and unarmed. A further data access alone does not clear it.
- R11: A high-byte (size code 1) data-register access clears no flag and leaves existing arming intact.
- R12: `dr_rd_stb_o` is 1 during a data read of size 0 or 2 and during a combined read. `dr_wr_stb_o` is 1 during a data write of size 0 or 2. Both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 9 | Per-flag set pulses from transmitter/receiver, bit positions as in the status word |
| acc_en | input | 1 | Bus access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 1 | 0 = status register, 1 = data register |
| acc_size | input | 2 | 0 low byte, 1 high byte, 2 half-word, 3 combined 32-bit read |
| wr_data_i | input | 16 | Write data (forwarded to the data buffer, ignored for status) |
| rx_data_i | input | 16 | Current receive data register contents |
| rd_data_o | output | 32 | Read data, valid in the access cycle |
| flags_o | output | 9 | Current flag values |
| dr_rd_stb_o | output | 1 | Data register consumed by this read |
| dr_wr_stb_o | output | 1 | Data register loaded by this write |

## Verification
Arming is internal, so a wrong armed state shows up only at the next data-register access. A flag that is wrongly armed drops one cycle after a data access that should have left it alone. A flag that is wrongly unarmed stays at 1 after that access. The bench therefore follows every arming read with the clearing access and checks `flags_o` on the cycle just after that access. It also places set pulses between the two steps and in the same cycle as the second step, where a faulty priority between set and clear would show up within one cycle.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

    localparam int NFLAGS  = 9;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int RSVD_W  = DATA_W - NFLAGS;

    // Positions that matter to the clearing rules
    localparam int BIT_TX_EMPTY = 8;
    localparam int BIT_TX_DONE  = 7;

    localparam logic [NFLAGS-1:0] TX_MASK     = 9'h180;
    localparam logic [NFLAGS-1:0] RESET_FLAGS = 9'h180;

    typedef enum logic [1:0] {
        SZ_LO   = 2'd0,
        SZ_HI   = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } acc_size_e;

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_DATA   = 1'b1;

    typedef enum logic [1:0] {
        FS_CLEAR   = 2'd0,
        FS_PENDING = 2'd1,
        FS_ARMED   = 2'd2
    } flag_state_e;

    typedef struct packed {
        logic status_rd;   // any status read, combined read included
        logic combo_rd;    // 32-bit combined read
        logic rx_finish;   // data read, low byte or half-word
        logic tx_finish;   // data write, low byte or half-word
    } acc_evt_t;

endpackage

// File: rtl/uart_flag_decode.sv
module uart_flag_decode
    import uart_flag_pkg::*;
(
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic                acc_reg,
    input  logic [1:0]          acc_size,
    input  logic [NFLAGS-1:0]   flags,
    input  logic [DATA_W-1:0]   rx_data,
    output acc_evt_t            evt,
    output logic [2*DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] status_word;
    logic              rd_any;
    logic              data_narrow;

    assign status_word = {{RSVD_W{1'b0}}, flags};
    assign rd_any      = acc_en && !acc_wr;
    assign data_narrow = (acc_reg == SEL_DATA) &&
                         (acc_size == SZ_LO || acc_size == SZ_HALF);

    always_comb begin
        evt.combo_rd  = rd_any && (acc_size == SZ_WORD);
        evt.status_rd = rd_any && ((acc_reg == SEL_STATUS) || (acc_size == SZ_WORD));
        evt.rx_finish = rd_any && data_narrow;
        evt.tx_finish = acc_en && acc_wr && data_narrow;
    end

    always_comb begin
        rd_data = '0;
        if (rd_any) begin
            if (acc_size == SZ_WORD) begin
                rd_data = {status_word, rx_data};
            end else if (acc_reg == SEL_STATUS) begin
                unique case (acc_size)
                    SZ_LO:   rd_data[BYTE_W-1:0] = status_word[BYTE_W-1:0];
                    SZ_HI:   rd_data[BYTE_W-1:0] = status_word[DATA_W-1:BYTE_W];
                    default: rd_data[DATA_W-1:0] = status_word;
                endcase
            end else begin
                unique case (acc_size)
                    SZ_LO:   rd_data[BYTE_W-1:0] = rx_data[BYTE_W-1:0];
                    SZ_HI:   rd_data[BYTE_W-1:0] = rx_data[DATA_W-1:BYTE_W];
                    default: rd_data[DATA_W-1:0] = rx_data;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_flag_cell.sv
module uart_flag_cell
    import uart_flag_pkg::*;
#(
    parameter bit IS_TX   = 1'b0,
    parameter bit RST_SET = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     set_pulse,
    input  acc_evt_t evt,
    output logic     flag
);

    localparam flag_state_e RST_STATE = RST_SET ? FS_PENDING : FS_CLEAR;

    flag_state_e state_q, state_d;
    logic        finish;
    logic        sweep;

    // Clearing access and combined-read sweep differ by flag class
    generate
        if (IS_TX) begin : g_tx
            assign finish = evt.tx_finish;
            assign sweep  = 1'b0;
        end else begin : g_rx
            assign finish = evt.rx_finish;
            assign sweep  = evt.combo_rd;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_CLEAR: begin
                if (set_pulse) state_d = FS_PENDING;
            end
            FS_PENDING: begin
                if (set_pulse)           state_d = FS_PENDING;
                else if (sweep)          state_d = FS_CLEAR;
                else if (evt.status_rd)  state_d = FS_ARMED;
            end
            FS_ARMED: begin
                if (set_pulse)           state_d = FS_PENDING;
                else if (sweep || finish) state_d = FS_CLEAR;
            end
            default: state_d = FS_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q != FS_CLEAR);
    end

endmodule

// File: rtl/uart_flag_unit.sv
module uart_flag_unit
    import uart_flag_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NFLAGS-1:0]   set_i,
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic                acc_reg,
    input  logic [1:0]          acc_size,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [DATA_W-1:0]   rx_data_i,
    output logic [2*DATA_W-1:0] rd_data_o,
    output logic [NFLAGS-1:0]   flags_o,
    output logic                dr_rd_stb_o,
    output logic                dr_wr_stb_o
);

    acc_evt_t          evt;
    logic [DATA_W-1:0] wr_unused;

    // Write data is consumed by the external data buffer only
    assign wr_unused = wr_data_i;

    uart_flag_decode u_dec (
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_reg  (acc_reg),
        .acc_size (acc_size),
        .flags    (flags_o),
        .rx_data  (rx_data_i),
        .evt      (evt),
        .rd_data  (rd_data_o)
    );

    generate
        for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
            uart_flag_cell #(
                .IS_TX   (TX_MASK[i]),
                .RST_SET (RESET_FLAGS[i])
            ) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_pulse (set_i[i]),
                .evt       (evt),
                .flag      (flags_o[i])
            );
        end
    endgenerate

    assign dr_rd_stb_o = evt.rx_finish || evt.combo_rd;
    assign dr_wr_stb_o = evt.tx_finish;

endmodule

// File: rtl/uart_flag_unit_chk.sv
module uart_flag_unit_chk
    import uart_flag_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [NFLAGS-1:0]   set_i,
    input logic                acc_en,
    input logic                acc_wr,
    input logic                acc_reg,
    input logic [1:0]          acc_size,
    input logic [2*DATA_W-1:0] rd_data_o,
    input logic [NFLAGS-1:0]   flags_o,
    input logic                dr_rd_stb_o,
    input logic                dr_wr_stb_o
);

    a_r3_rx_fall_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~flags_o[6:0] & $past(flags_o[6:0]))) |->
        $past(acc_en && !acc_wr && (acc_size == SZ_WORD ||
              (acc_reg == SEL_DATA && acc_size != SZ_HI))));

    a_r4_tx_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~flags_o[8:7] & $past(flags_o[8:7]))) |->
        $past(acc_en && acc_wr && acc_reg == SEL_DATA &&
              (acc_size == SZ_LO || acc_size == SZ_HALF)));

    a_r7_combo_sweeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_size == SZ_WORD) |=>
        ((flags_o[6:0] & ~$past(set_i[6:0])) == '0));

    a_r7_combo_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_size == SZ_WORD) |=>
        ((flags_o[8:7] & $past(flags_o[8:7])) == $past(flags_o[8:7])));

    a_r8_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_reg == SEL_STATUS) |=>
        ((flags_o & $past(flags_o)) == $past(flags_o)));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dr_rd_stb_o && dr_wr_stb_o));

    a_r12_wr_stb_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        dr_wr_stb_o |-> (acc_en && acc_wr));

endmodule

bind uart_flag_unit uart_flag_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (set_i),
    .acc_en      (acc_en),
    .acc_wr      (acc_wr),
    .acc_reg     (acc_reg),
    .acc_size    (acc_size),
    .rd_data_o   (rd_data_o),
    .flags_o     (flags_o),
    .dr_rd_stb_o (dr_rd_stb_o),
    .dr_wr_stb_o (dr_wr_stb_o)
);

// File: tb/tb_uart_flag_unit.sv
module tb_uart_flag_unit;

    localparam int CLK_P = 10;
    localparam logic [15:0] RXV = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  set_i = '0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_reg = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rx_data_i = RXV;
    logic [31:0] rd_data_o;
    logic [8:0]  flags_o;
    logic        dr_rd_stb_o;
    logic        dr_wr_stb_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    uart_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .set_i(set_i), .acc_en(acc_en),
        .acc_wr(acc_wr), .acc_reg(acc_reg), .acc_size(acc_size),
        .wr_data_i(wr_data_i), .rx_data_i(rx_data_i), .rd_data_o(rd_data_o),
        .flags_o(flags_o), .dr_rd_stb_o(dr_rd_stb_o), .dr_wr_stb_o(dr_wr_stb_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one access cycle, optional same-cycle set pulse
    task automatic access(bit wr, bit rg, logic [1:0] sz, logic [15:0] wd,
                          logic [8:0] setm, logic [31:0] exp_rd, string tag);
        bit exp_rs;
        bit exp_ws;
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_reg = rg; acc_size = sz;
        wr_data_i = wd; set_i = setm;
        if (!wr) sb_q.push_back('{exp_rd, tag});
        exp_rs = !wr && (sz == 2'd3 || (rg && (sz == 2'd0 || sz == 2'd2)));
        exp_ws = wr && rg && (sz == 2'd0 || sz == 2'd2);
        #(CLK_P/4);
        check({"R12 rd_stb ", tag}, {31'b0, dr_rd_stb_o}, {31'b0, exp_rs});
        check({"R12 wr_stb ", tag}, {31'b0, dr_wr_stb_o}, {31'b0, exp_ws});
        @(negedge clk);
        acc_en = 1'b0; set_i = '0;
    endtask

    task automatic pulse(logic [8:0] m);
        @(negedge clk); set_i = m;
        @(negedge clk); set_i = '0;
    endtask

    task automatic flags_is(string tag, logic [8:0] exp);
        check({"flags ", tag}, {23'b0, flags_o}, {23'b0, exp});
    endtask

    // Monitor: compare read data against the scoreboard
    always @(negedge clk) begin
        #(CLK_P/4);
        if (rst_n && acc_en && !acc_wr) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check({"rdata ", it.tag}, rd_data_o, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        flags_is("R1 during reset", 9'h180);
        rst_n = 1'b1;
        @(negedge clk);
        flags_is("R1 after reset", 9'h180);

        // R2 status views (these reads arm TDRE/TC)
        access(0, 0, 2'd2, 0, 0, 32'h0000_0180, "R2 half");
        access(0, 0, 2'd1, 0, 0, 32'h0000_0001, "R2 high byte");
        access(0, 0, 2'd0, 0, 0, 32'h0000_0080, "R2 low byte");

        // R5 unarmed RDRF survives data read; R4 read leaves tx flags
        pulse(9'h040);
        access(0, 1, 2'd2, 0, 0, {16'h0, RXV}, "R5 data half");
        flags_is("R5 unarmed kept / R4 read no tx clear", 9'h1C0);

        // R3 write leaves rx flag; R4 armed tx flags cleared by write
        access(0, 0, 2'd0, 0, 0, 32'h0000_00C0, "R3 arm read");
        access(1, 1, 2'd2, 16'h1234, 0, 0, "R4 data write");
        flags_is("R3 write no rx clear / R4 tx cleared", 9'h040);
        access(0, 1, 2'd0, 0, 0, 32'h0000_00C3, "R3 data low");
        flags_is("R3 rx cleared", 9'h000);

        // R6 flag set between arm and finish
        pulse(9'h008);
        access(0, 0, 2'd2, 0, 0, 32'h0000_0008, "R6 arm read");
        pulse(9'h002);
        access(0, 1, 2'd2, 0, 0, {16'h0, RXV}, "R6 data");
        flags_is("R6 late flag kept", 9'h002);
        access(0, 0, 2'd2, 0, 0, 32'h0000_0002, "R6 rearm");
        access(0, 1, 2'd2, 0, 0, {16'h0, RXV}, "R6 data2");
        flags_is("R6 late flag cleared", 9'h000);

        // R9 high byte read arms low byte flag
        pulse(9'h001);
        access(0, 0, 2'd1, 0, 0, 32'h0000_0000, "R9 high read");
        access(0, 1, 2'd0, 0, 0, 32'h0000_00C3, "R9 data");
        flags_is("R9 cross-byte arm", 9'h000);

        // R8 status write inert
        pulse(9'h004);
        access(0, 0, 2'd2, 0, 0, 32'h0000_0004, "R8 arm read");
        access(1, 0, 2'd2, 16'h0000, 0, 0, "R8 status write");
        flags_is("R8 write no effect", 9'h004);
        access(0, 1, 2'd2, 0, 0, {16'h0, RXV}, "R8 data");
        flags_is("R8 arming survived", 9'h000);

        // R7 combined read
        pulse(9'h1D0);
        flags_is("R7 pre", 9'h1D0);
        access(0, 0, 2'd3, 0, 0, {16'h01D0, RXV}, "R7 combined");
        flags_is("R7 rx swept tx kept", 9'h180);
        access(1, 1, 2'd0, 16'h0055, 0, 0, "R7 data write");
        flags_is("R7 tx armed by combined", 9'h000);

        // R10 set and clear same cycle
        pulse(9'h020);
        access(0, 0, 2'd2, 0, 0, 32'h0000_0020, "R10 arm read");
        access(0, 1, 2'd2, 0, 9'h020, {16'h0, RXV}, "R10 collide");
        flags_is("R10 set wins", 9'h020);
        access(0, 1, 2'd2, 0, 0, {16'h0, RXV}, "R10 data again");
        flags_is("R10 unarmed", 9'h020);
        access(0, 0, 2'd2, 0, 0, 32'h0000_0020, "R10 rearm");
        access(0, 1, 2'd2, 0, 0, {16'h0, RXV}, "R10 data3");
        flags_is("R10 finally cleared", 9'h000);

        // R11 high-byte data access
        pulse(9'h010);
        access(0, 0, 2'd2, 0, 0, 32'h0000_0010, "R11 arm read");
        access(0, 1, 2'd1, 0, 0, 32'h0000_00A5, "R11 data high");
        flags_is("R11 no clear", 9'h010);
        access(0, 1, 2'd0, 0, 0, 32'h0000_00C3, "R11 data low");
        flags_is("R11 arming kept", 9'h000);

        repeat (2) @(negedge clk);
        check("scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule